// File: doc/BRIEF.md
# Patchable Array Summation Engine

This block takes over a common software loop from a host processor: it walks a signed 32-bit integer array in memory, starting from a base byte address, and folds each element into an accumulator until the loop index reaches a count. The host supplies the base address and element count with a one-cycle start pulse. The engine then issues single-word load requests on a simple request/valid memory port and reports the final accumulator with a one-cycle done pulse.

The engine is built for patching after fabrication. Its whole architectural state forms one serial chain: the control state, loop index, accumulator, base, count, index step, index start value and fold operator. The host can read this chain and overwrite it one bit per clock whenever the engine is parked. A patch point can be armed on a chosen loop index. When the engine is about to run the loop body for that index, it parks and raises an exception. The host shifts the state out, performs the patched work itself, shifts the edited state back in, and pulses resume. The engine then continues from whatever control state and data the chain now holds. The index start value, the index step and the fold operator are chain fields rather than fixed logic, so a patch can also change them.

Top module: `arrsum_core`

## Requirements
- R1: After a synchronous reset, done, exc, mem_req, result and mem_addr are 0, and the chain holds control state 0, index 0, accumulator 0, base 0, count 0, step 1, start value 0 and operator 0.
- R2: With operator add, the result equals the sum of the count elements in signed 32-bit wrap-around arithmetic. It appears on result together with a done pulse that lasts one cycle, and done and exc are never high together.
- R3: A count of zero or a negative count produces done with result 0 and no memory request.
- R4: Each load is a one-cycle mem_req pulse at address base + 4 × index. The engine folds the returned word only when mem_rvalid arrives, however many cycles that takes.
- R5: The 2-bit operator field selects the fold: 0 add, 1 subtract (acc − element), 2 bitwise XOR, 3 signed maximum of acc and element.
- R6: The index begins at the start-value field and advances by the step field after each fold. The loop runs while index < count, compared as signed values.
- R7: With patch_en high, when the loop test passes for an index equal to patch_trig, the engine parks with exc high before issuing that load. exc stays high, and no request is issued, until the host pulses start or resume.
- R8: While the engine is parked (idle or on an exception), each cycle with scan_en high shifts the 197-bit chain by one. scan_out shows the current top bit and scan_in enters at the bottom. Fields from the top: control state (3 bits; 0 idle, 1 entry, 2 loop test, 3 load, 4 wait, 5 exit), index (32), accumulator (32), base (32), count (32), step (32), start value (32), operator (2). Each field is sent MSB first.
- R9: A resume pulse clears exc, and the engine continues from the control state, index and accumulator held in the chain. This includes values the host scanned in.
- R10: While the engine is running (not parked), scan_en and scan_in have no effect on the chain or on the result.
- R11: A start pulse while the engine is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run with base_addr and count (taken only when parked) |
| base_addr | input | 32 | Byte address of element 0 |
| count | input | 32 | Signed loop bound |
| resume | input | 1 | Continue from chain state after a patch (taken only when parked) |
| patch_en | input | 1 | Arms the patch point |
| patch_trig | input | 32 | Loop index at which the patch point fires |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Final accumulator, registered on completion |
| exc | output | 1 | Patch exception pending |
| mem_req | output | 1 | One-cycle load request |
| mem_addr | output | 32 | Load byte address |
| mem_rvalid | input | 1 | Load data valid |
| mem_rdata | input | 32 | Load data |
| scan_en | input | 1 | Shift the state chain by one bit |
| scan_in | input | 1 | Serial chain input |
| scan_out | output | 1 | Serial chain output (top bit) |

## Verification
A corrupted index or step shows up on the next memory request, because mem_addr is formed from the index and is visible within a few cycles of the fault. A corrupted accumulator or operator stays hidden until the done pulse at the end of the run. A corrupted control state shows either as a request that should not happen or as a done pulse too early or too late. At any patch point, the serial chain exposes every one of these fields within 197 cycles. The directed cases compare the expected chain image exactly at those points, so faults in field order or content are caught before the run completes.

// File: rtl/arrsum_pkg.sv
package arrsum_pkg;
  parameter int DW  = 32;
  parameter int AW  = 32;
  parameter int CSW = 3;
  parameter int OPW = 2;
  localparam int BYTE_SH = $clog2(DW / 8);

  typedef enum logic [CSW-1:0] {
    CS_IDLE  = 3'd0,
    CS_ENTRY = 3'd1,
    CS_TEST  = 3'd2,
    CS_LOAD  = 3'd3,
    CS_WAIT  = 3'd4,
    CS_EXIT  = 3'd5
  } cstate_t;

  typedef enum logic [OPW-1:0] {
    FOLD_ADD = 2'd0,
    FOLD_SUB = 2'd1,
    FOLD_XOR = 2'd2,
    FOLD_MAX = 2'd3
  } fold_t;

  // field order of this struct is the serial chain order, top bit first
  typedef struct packed {
    cstate_t         cs;
    logic [DW-1:0]   idx;
    logic [DW-1:0]   acc;
    logic [AW-1:0]   base;
    logic [DW-1:0]   cnt;
    logic [DW-1:0]   step;
    logic [DW-1:0]   init;
    fold_t           op;
  } arch_t;

  localparam int CHAIN_W = $bits(arch_t);
endpackage

// File: rtl/arrsum_fu.sv
module arrsum_fu
  import arrsum_pkg::*;
#(
  parameter int W = DW
) (
  input  fold_t        op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] elem,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      FOLD_ADD: y = acc + elem;
      FOLD_SUB: y = acc - elem;
      FOLD_XOR: y = acc ^ elem;
      FOLD_MAX: y = ($signed(elem) > $signed(acc)) ? elem : acc;
      default:  y = acc + elem;
    endcase
  end
endmodule

// File: rtl/arrsum_chain.sv
module arrsum_chain
  import arrsum_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  shift_en,
  input  logic  scan_in,
  input  logic  upd_en,
  input  arch_t nxt,
  output arch_t cur,
  output logic  scan_out
);
  logic [CHAIN_W-1:0] flat;
  arch_t              rst_val;

  assign flat = cur;
  assign scan_out = flat[CHAIN_W-1];

  always_comb begin
    rst_val      = '0;
    rst_val.cs   = CS_IDLE;
    rst_val.step = DW'(1);
    rst_val.op   = FOLD_ADD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= rst_val;
    end else if (shift_en) begin
      cur <= arch_t'({flat[CHAIN_W-2:0], scan_in});
    end else if (upd_en) begin
      cur <= nxt;
    end
  end
endmodule

// File: rtl/arrsum_ctrl.sv
module arrsum_ctrl
  import arrsum_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  arch_t         cur,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [DW-1:0] count,
  input  logic          resume,
  input  logic          scan_en,
  input  logic          patch_en,
  input  logic [DW-1:0] patch_trig,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] fold_y,
  output arch_t         nxt,
  output logic          upd_en,
  output logic          parked,
  output logic          done,
  output logic [DW-1:0] result,
  output logic          exc,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr
);
  logic          host_ok;
  logic          park_d;
  logic          exc_d;
  logic          req_d;
  logic          fin_d;
  logic [AW-1:0] off;

  assign host_ok = parked && !scan_en;
  assign off     = AW'(cur.idx) << BYTE_SH;

  always_comb begin
    nxt    = cur;
    upd_en = 1'b0;
    park_d = parked;
    exc_d  = exc;
    req_d  = 1'b0;
    fin_d  = 1'b0;
    if (parked) begin
      if (host_ok && start) begin
        upd_en   = 1'b1;
        nxt.cs   = CS_ENTRY;
        nxt.base = base_addr;
        nxt.cnt  = count;
        park_d   = 1'b0;
        exc_d    = 1'b0;
      end else if (host_ok && resume) begin
        park_d = 1'b0;
        exc_d  = 1'b0;
      end
    end else begin
      upd_en = 1'b1;
      case (cur.cs)
        CS_ENTRY: begin
          nxt.idx = cur.init;
          nxt.acc = '0;
          nxt.cs  = CS_TEST;
        end
        CS_TEST: begin
          if ($signed(cur.idx) < $signed(cur.cnt)) begin
            nxt.cs = CS_LOAD;
            if (patch_en && (cur.idx == patch_trig)) begin
              park_d = 1'b1;
              exc_d  = 1'b1;
            end
          end else begin
            nxt.cs = CS_EXIT;
          end
        end
        CS_LOAD: begin
          req_d  = 1'b1;
          nxt.cs = CS_WAIT;
        end
        CS_WAIT: begin
          if (mem_rvalid) begin
            nxt.acc = fold_y;
            nxt.idx = cur.idx + cur.step;
            nxt.cs  = CS_TEST;
          end
        end
        CS_EXIT: begin
          fin_d  = 1'b1;
          nxt.cs = CS_IDLE;
          park_d = 1'b1;
        end
        default: begin
          nxt.cs = CS_IDLE;
          park_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      parked   <= 1'b1;
      exc      <= 1'b0;
      done     <= 1'b0;
      result   <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
    end else begin
      parked  <= park_d;
      exc     <= exc_d;
      done    <= fin_d;
      mem_req <= req_d;
      if (fin_d) result <= cur.acc;
      if (req_d) mem_addr <= cur.base + off;
    end
  end
endmodule

// File: rtl/arrsum_core.sv
module arrsum_core
  import arrsum_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [DW-1:0] count,
  input  logic          resume,
  input  logic          patch_en,
  input  logic [DW-1:0] patch_trig,
  output logic          done,
  output logic [DW-1:0] result,
  output logic          exc,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  input  logic          scan_en,
  input  logic          scan_in,
  output logic          scan_out
);
  arch_t         cur;
  arch_t         nxt;
  logic          upd_en;
  logic          parked;
  logic [DW-1:0] fold_y;

  arrsum_fu #(.W(DW)) u_fu (
    .op   (cur.op),
    .acc  (cur.acc),
    .elem (mem_rdata),
    .y    (fold_y)
  );

  arrsum_chain u_chain (
    .clk      (clk),
    .rst      (rst),
    .shift_en (scan_en && parked),
    .scan_in  (scan_in),
    .upd_en   (upd_en),
    .nxt      (nxt),
    .cur      (cur),
    .scan_out (scan_out)
  );

  arrsum_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cur        (cur),
    .start      (start),
    .base_addr  (base_addr),
    .count      (count),
    .resume     (resume),
    .scan_en    (scan_en),
    .patch_en   (patch_en),
    .patch_trig (patch_trig),
    .mem_rvalid (mem_rvalid),
    .fold_y     (fold_y),
    .nxt        (nxt),
    .upd_en     (upd_en),
    .parked     (parked),
    .done       (done),
    .result     (result),
    .exc        (exc),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr)
  );
endmodule

// File: rtl/arrsum_core_chk.sv
module arrsum_core_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic resume,
  input logic scan_en,
  input logic done,
  input logic exc,
  input logic mem_req
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R2
  AST_DONE_EXC_APART: assert property (@(posedge clk) disable iff (rst) !(done && exc)); // R2
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) mem_req |=> !mem_req); // R4
  AST_EXC_NO_REQ: assert property (@(posedge clk) disable iff (rst) exc |-> !mem_req); // R7
  AST_EXC_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (exc && !(!scan_en && (start || resume))) |=> exc); // R7
endmodule

bind arrsum_core arrsum_core_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .resume  (resume),
  .scan_en (scan_en),
  .done    (done),
  .exc     (exc),
  .mem_req (mem_req)
);

// File: tb/tb_arrsum_core.sv
`timescale 1ns/1ps
module tb_arrsum_core;
  localparam int SL = 197;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [31:0] count = '0;
  logic        resume = 1'b0;
  logic        patch_en = 1'b0;
  logic [31:0] patch_trig = '0;
  logic        done;
  logic [31:0] result;
  logic        exc;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        scan_en = 1'b0;
  logic        scan_in = 1'b0;
  logic        scan_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] mem [16];
  int          lat = 1;
  int          pend = 0;
  logic [3:0]  pidx = '0;
  logic [31:0] alog [64];
  int          nreq = 0;

  always #10 clk = ~clk;

  arrsum_core dut (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr), .count(count),
    .resume(resume), .patch_en(patch_en), .patch_trig(patch_trig),
    .done(done), .result(result), .exc(exc), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .scan_en(scan_en), .scan_in(scan_in), .scan_out(scan_out)
  );

  // memory model: answers each request after lat cycles
  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem[pidx];
      end
    end
    if (mem_req) begin
      pend = lat;
      pidx = mem_addr[5:2];
      if (nreq < 64) alog[nreq] = mem_addr;
      nreq++;
    end
  end

  task automatic chk(input string tag, input string what, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [SL-1:0] mk(input logic [2:0] cs, input logic [31:0] i, input logic [31:0] s,
                                       input logic [31:0] p, input logic [31:0] n, input logic [31:0] st,
                                       input logic [31:0] ini, input logic [1:0] op);
    return {cs, i, s, p, n, st, ini, op};
  endfunction

  function automatic logic [31:0] fold(input logic [1:0] op, input logic [31:0] a, input logic [31:0] e);
    case (op)
      2'd0: return a + e;
      2'd1: return a - e;
      2'd2: return a ^ e;
      default: return ($signed(e) > $signed(a)) ? e : a;
    endcase
  endfunction

  task automatic scan_xfer(input logic [SL-1:0] din, output logic [SL-1:0] dout);
    for (int k = SL - 1; k >= 0; k--) begin
      @(negedge clk);
      dout[k] = scan_out;
      scan_en = 1'b1;
      scan_in = din[k];
    end
    @(negedge clk);
    scan_en = 1'b0;
    scan_in = 1'b0;
  endtask

  task automatic go(input logic [31:0] b, input logic [31:0] n);
    @(negedge clk);
    start = 1'b1; base_addr = b; count = n;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag, input int maxc);
    bit seen = 0;
    for (int c = 0; c < maxc && !seen; c++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(tag, "done seen", seen, 1);
  endtask

  task automatic cfg(input logic [1:0] op, input logic [31:0] st, input logic [31:0] ini);
    logic [SL-1:0] d;
    scan_xfer(mk(3'd0, 0, 0, 0, 0, st, ini, op), d);
  endtask

  task automatic run_check(input string tag, input logic [31:0] b, input logic [31:0] n, input int l,
                           input logic [1:0] op, input logic [31:0] st, input logic [31:0] ini);
    logic [31:0] acc = 0;
    int iters = 0;
    int r0;
    cfg(op, st, ini);
    lat = l;
    r0 = nreq;
    go(b, n);
    wait_done(tag, 400);
    for (int i = int'(ini); i < int'(n); i += int'(st)) begin
      acc = fold(op, acc, mem[i]);
      if (nreq > r0 + iters) chk(tag, "address", alog[r0 + iters], b + 32'(4 * i));
      iters++;
    end
    chk(tag, "result", result, acc);
    chk(tag, "request count", nreq - r0, iters);
  endtask

  task automatic t_reset();
    logic [SL-1:0] d;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "done", done, 0);
    chk("R1", "exc", exc, 0);
    chk("R1", "mem_req", mem_req, 0);
    chk("R1", "result", result, 0);
    chk("R1", "mem_addr", mem_addr, 0);
    scan_xfer(mk(3'd0, 0, 0, 0, 0, 1, 0, 2'd0), d);
    chk("R1", "reset chain image", d, mk(3'd0, 0, 0, 0, 0, 1, 0, 2'd0));
  endtask

  task automatic t_sum();
    mem[0] = 32'd17; mem[1] = -32'sd40; mem[2] = 32'd3; mem[3] = 32'd100; mem[4] = -32'sd1;
    run_check("R2", 32'h1000, 5, 1, 2'd0, 1, 0);
    mem[0] = 32'h7fffffff; mem[1] = 32'd1; mem[2] = 32'd5; mem[3] = -32'sd3; mem[4] = 32'd10;
    run_check("R4", 32'h2000, 5, 4, 2'd0, 1, 0);
    chk("R2", "wrapped sum", result, 32'h8000000c);
  endtask

  task automatic t_empty();
    run_check("R3", 32'h1000, 0, 1, 2'd0, 1, 0);
    run_check("R3", 32'h1000, -32'sd3, 1, 2'd0, 1, 0);
  endtask

  task automatic t_ops();
    mem[0] = 32'd5; mem[1] = -32'sd9; mem[2] = 32'd12; mem[3] = 32'h0f0f0003;
    for (int op = 0; op < 4; op++) run_check("R5", 32'h1000, 4, 2, 2'(op), 1, 0);
  endtask

  task automatic t_step();
    for (int k = 0; k < 8; k++) mem[k] = 32'(k * 11 + 1);
    run_check("R6", 32'h1000, 7, 1, 2'd0, 2, 1);
    run_check("R6", 32'h1000, 6, 3, 2'd1, 3, 0);
  endtask

  task automatic t_ignore();
    logic [SL-1:0] d;
    int r0;
    logic [31:0] s;
    mem[0] = 32'd2; mem[1] = 32'd4; mem[2] = 32'd8; mem[3] = 32'd16;
    s = 32'd30;
    cfg(2'd0, 1, 0);
    lat = 8;
    r0 = nreq;
    go(32'h1000, 4);
    while (nreq == r0) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      scan_en = 1'b1; scan_in = 1'b1;
      @(negedge clk);
    end
    scan_en = 1'b0; scan_in = 1'b0;
    start = 1'b1; base_addr = 32'h3000; count = 1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R11", 400);
    chk("R10", "result after stray shifts", result, s);
    chk("R11", "request count", nreq - r0, 4);
    chk("R11", "last address", alog[r0 + 3], 32'h100c);
    scan_xfer(mk(3'd0, 0, 0, 0, 0, 1, 0, 2'd0), d);
    chk("R10", "chain after run", d, mk(3'd0, 4, s, 32'h1000, 4, 1, 0, 2'd0));
  endtask

  task automatic t_patch_skip();
    logic [SL-1:0] d;
    int r0;
    logic [31:0] part;
    mem[0] = 32'd7; mem[1] = 32'd9; mem[2] = 32'd500; mem[3] = 32'd20; mem[4] = 32'd30;
    part = 32'd16;
    cfg(2'd0, 1, 0);
    lat = 2;
    patch_en = 1'b1; patch_trig = 2;
    r0 = nreq;
    go(32'h1000, 5);
    for (int c = 0; c < 200 && !exc; c++) @(negedge clk);
    chk("R7", "exc raised", exc, 1);
    chk("R7", "loads before patch", nreq - r0, 2);
    repeat (5) @(negedge clk);
    chk("R7", "exc held", exc, 1);
    chk("R7", "no load while parked", nreq - r0, 2);
    scan_xfer(mk(3'd2, 3, part + 32'd1000, 32'h1000, 5, 1, 0, 2'd0), d);
    chk("R8", "chain at patch point", d, mk(3'd3, 2, part, 32'h1000, 5, 1, 0, 2'd0));
    chk("R7", "exc after scan", exc, 1);
    resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
    chk("R9", "exc cleared", exc, 0);
    wait_done("R9", 400);
    chk("R9", "patched result", result, part + 32'd1050);
    chk("R9", "loads after patch", nreq - r0, 4);
    chk("R9", "skipped element", alog[r0 + 2], 32'h100c);
    patch_en = 1'b0;
  endtask

  task automatic t_patch_plain();
    logic [SL-1:0] d;
    int r0;
    mem[0] = 32'd1; mem[1] = 32'd2; mem[2] = 32'd3;
    cfg(2'd0, 1, 0);
    lat = 1;
    patch_en = 1'b1; patch_trig = 0;
    r0 = nreq;
    go(32'h1000, 3);
    for (int c = 0; c < 200 && !exc; c++) @(negedge clk);
    chk("R7", "exc at index 0", exc, 1);
    chk("R7", "no load yet", nreq - r0, 0);
    scan_xfer(mk(3'd3, 0, 0, 32'h1000, 3, 1, 0, 2'd0), d);
    chk("R8", "chain at index 0", d, mk(3'd3, 0, 0, 32'h1000, 3, 1, 0, 2'd0));
    resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
    wait_done("R9", 400);
    chk("R9", "unchanged resume result", result, 32'd6);
    chk("R9", "unchanged resume loads", nreq - r0, 3);
    patch_en = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < 16; k++) mem[k] = '0;
    t_reset();
    t_sum();
    t_empty();
    t_ops();
    t_step();
    t_ignore();
    t_patch_skip();
    t_patch_plain();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule